// File: doc/BRIEF.md
# H-Bridge Gate Command Sequencer

This block turns the control inputs of a DC motor full bridge into four gate commands: a high-side and a low-side command for each of the two half-bridges (leg A drives motor terminal 1, leg B drives motor terminal 2). The inputs are a direction bit, a drive enable, a decay-mode select, an active-low standby input, and three signals from the current regulator. The regulator signals are a chop request, the chop phase, and a flag saying that the load current has reached zero.

A combinational decoder picks one operating case and gives each leg a target: high, low or released. Released means both switches are off, which is the high-impedance state. Each leg has its own state machine, with states `S_OFF`, `S_HIGH`, `S_LOW` and `S_DEAD`. When a leg leaves `S_HIGH` or `S_LOW`, it always passes through `S_DEAD` for `DEAD_CYC` clock cycles with both switches off. Only then does it turn on the opposite switch or settle in `S_OFF`. From `S_OFF`, a leg turns a switch on at the next edge. The named transitions are: off-to-high and off-to-low on a new target; high-to-dead and low-to-dead when the target changes; and dead-to-high, dead-to-low or dead-to-off when the count expires, following the target present at that moment.

Top module: `hbridge_gate_seq`

## Requirements
- R1: With standby inactive, enable high and no chop, direction 1 settles with leg A high-side on and leg B low-side on.
- R2: Under the same conditions, direction 0 settles with leg A low-side on and leg B high-side on.
- R3: With enable low and decay select 1 (brake), both legs settle with their high-side on, whatever the direction.
- R4: With enable low and decay select 0 (fast decay), direction 1 settles with leg A low and leg B high, and direction 0 settles with leg A high and leg B low.
- R5: While standby_n is 0, all four gate commands are 0 from the first clock edge on, whatever the other inputs are.
- R6: In fast decay with zero_cur at 1, both legs are released, so all commands are 0. zero_cur has no effect in forward or reverse drive.
- R7: During a chop with direction 1, leg B stays high. Leg A is low when chop_slow is 0 and high when chop_slow is 1. With direction 0, leg A stays high and leg B follows chop_slow in the same way.
- R8: After a leg's high-side or low-side command turns off, both of that leg's commands stay 0 for exactly DEAD_CYC cycles. The leg then takes up the target it has at that time.
- R9: A leg never asserts its high-side and low-side commands in the same cycle.
- R10: After reset, all commands are 0. A leg in the off state turns a switch on at the first clock edge after its target is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_n | input | 1 | 0 = standby, both legs released |
| dir | input | 1 | Direction |
| en | input | 1 | Drive enable |
| decay_sel | input | 1 | 1 = brake, 0 = fast decay when enable is low |
| chop | input | 1 | Current-limit chop request |
| chop_slow | input | 1 | Chop phase: 1 = slow part, 0 = fast part |
| zero_cur | input | 1 | Load current has reached zero |
| hs_a | output | 1 | Leg A high-side command |
| ls_a | output | 1 | Leg A low-side command |
| hs_b | output | 1 | Leg B high-side command |
| ls_b | output | 1 | Leg B low-side command |

## Verification
The assertions check three properties on every cycle: that no leg ever turns both of its switches on, that every switch-on follows at least DEAD_CYC all-off cycles, and that standby or a fast-decay zero-current condition removes all drive at the next edge. The bench's scenarios are needed to show that each decode case reaches the correct final levels. They also show that the dead window lasts exactly DEAD_CYC cycles, and that a target which changes during the window is the one the leg takes up.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        TGT_Z  = 2'd0,
        TGT_HI = 2'd1,
        TGT_LO = 2'd2
    } leg_tgt_t;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2,
        S_DEAD = 2'd3
    } leg_state_t;

    typedef enum logic [2:0] {
        OP_STBY,
        OP_DRIVE,
        OP_CHOP,
        OP_BRAKE,
        OP_FAST,
        OP_FAST_Z
    } bridge_op_t;

endpackage

// File: rtl/hb_decode.sv
module hb_decode
    import hbg_pkg::*;
(
    input  logic     standby_n,
    input  logic     dir,
    input  logic     en,
    input  logic     decay_sel,
    input  logic     chop,
    input  logic     chop_slow,
    input  logic     zero_cur,
    output leg_tgt_t tgt_a,
    output leg_tgt_t tgt_b
);

    bridge_op_t op;
    leg_tgt_t   chop_leg;

    always_comb begin
        if (!standby_n)     op = OP_STBY;
        else if (en && chop) op = OP_CHOP;
        else if (en)         op = OP_DRIVE;
        else if (decay_sel)  op = OP_BRAKE;
        else if (zero_cur)   op = OP_FAST_Z;
        else                 op = OP_FAST;
    end

    assign chop_leg = chop_slow ? TGT_HI : TGT_LO;

    always_comb begin
        tgt_a = TGT_Z;
        tgt_b = TGT_Z;
        unique case (op)
            OP_STBY, OP_FAST_Z: begin
                tgt_a = TGT_Z;
                tgt_b = TGT_Z;
            end
            OP_DRIVE: begin
                tgt_a = dir ? TGT_HI : TGT_LO;
                tgt_b = dir ? TGT_LO : TGT_HI;
            end
            OP_CHOP: begin
                tgt_a = dir ? chop_leg : TGT_HI;
                tgt_b = dir ? TGT_HI   : chop_leg;
            end
            OP_BRAKE: begin
                tgt_a = TGT_HI;
                tgt_b = TGT_HI;
            end
            OP_FAST: begin
                tgt_a = dir ? TGT_LO : TGT_HI;
                tgt_b = dir ? TGT_HI : TGT_LO;
            end
            default: begin
                tgt_a = TGT_Z;
                tgt_b = TGT_Z;
            end
        endcase
    end

endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 88
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_tgt_t tgt,
    output logic     hs,
    output logic     ls
);

    localparam int CW = $clog2(DEAD_CYC + 1);

    leg_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_OFF: begin
                if (tgt == TGT_HI)      state_d = S_HIGH;
                else if (tgt == TGT_LO) state_d = S_LOW;
            end
            S_HIGH: begin
                if (tgt != TGT_HI) begin
                    state_d = S_DEAD;
                    cnt_d   = CW'(DEAD_CYC - 1);
                end
            end
            S_LOW: begin
                if (tgt != TGT_LO) begin
                    state_d = S_DEAD;
                    cnt_d   = CW'(DEAD_CYC - 1);
                end
            end
            S_DEAD: begin
                if (cnt_q == '0) begin
                    unique case (tgt)
                        TGT_HI:  state_d = S_HIGH;
                        TGT_LO:  state_d = S_LOW;
                        default: state_d = S_OFF;
                    endcase
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = S_OFF;
        endcase
    end

    always_comb begin
        hs = (state_q == S_HIGH);
        ls = (state_q == S_LOW);
    end

    // Cycles spent with both switches off, saturating at DEAD_CYC.
    logic [CW-1:0] off_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    off_run_q <= CW'(DEAD_CYC);
        else if (hs || ls)             off_run_q <= '0;
        else if (off_run_q < CW'(DEAD_CYC)) off_run_q <= off_run_q + 1'b1;
    end

    // R9
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs && ls));

    // R8
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs) || $rose(ls)) |-> (off_run_q >= CW'(DEAD_CYC)));

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 88
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_n,
    input  logic dir,
    input  logic en,
    input  logic decay_sel,
    input  logic chop,
    input  logic chop_slow,
    input  logic zero_cur,
    output logic hs_a,
    output logic ls_a,
    output logic hs_b,
    output logic ls_b
);

    localparam int NLEG = 2;

    leg_tgt_t   tgt [NLEG];
    logic [NLEG-1:0] hs_v, ls_v;

    hb_decode u_dec (
        .standby_n (standby_n),
        .dir       (dir),
        .en        (en),
        .decay_sel (decay_sel),
        .chop      (chop),
        .chop_slow (chop_slow),
        .zero_cur  (zero_cur),
        .tgt_a     (tgt[0]),
        .tgt_b     (tgt[1])
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .tgt   (tgt[g]),
            .hs    (hs_v[g]),
            .ls    (ls_v[g])
        );
    end

    assign hs_a = hs_v[0];
    assign ls_a = ls_v[0];
    assign hs_b = hs_v[1];
    assign ls_b = ls_v[1];

    // R5
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |=> !(hs_a || ls_a || hs_b || ls_b));

    // R6
    zero_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_n && !en && !decay_sel && zero_cur) |=> !(hs_a || ls_a || hs_b || ls_b));

endmodule

// File: tb/hbridge_gate_seq_test.sv
`timescale 1ns/1ps
module hbridge_gate_seq_test;

    localparam int DT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby_n = 1'b0, dir = 1'b0, en = 1'b0, decay_sel = 1'b0;
    logic chop = 1'b0, chop_slow = 1'b0, zero_cur = 1'b0;
    logic hs_a, ls_a, hs_b, ls_b;

    always #2 clk = ~clk;

    hbridge_gate_seq #(.DEAD_CYC(DT)) uut (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n), .dir(dir), .en(en),
        .decay_sel(decay_sel), .chop(chop), .chop_slow(chop_slow),
        .zero_cur(zero_cur), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
    );

    typedef struct {
        logic [3:0] v;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model leg state: 0 off, 1 high, 2 low, 3 dead
    int m_st [2];
    int m_cnt[2];

    // Target per leg from the requirements: 0 released, 1 high, 2 low
    function automatic void targets(input logic sb, d, e, ds, c, cs, z,
                                    output int ta, output int tb);
        if (!sb)                 begin ta = 0; tb = 0; end
        else if (e && c) begin
            if (d) begin ta = cs ? 1 : 2; tb = 1; end
            else   begin ta = 1; tb = cs ? 1 : 2; end
        end
        else if (e)              begin ta = d ? 1 : 2; tb = d ? 2 : 1; end
        else if (ds)             begin ta = 1; tb = 1; end
        else if (z)              begin ta = 0; tb = 0; end
        else                     begin ta = d ? 2 : 1; tb = d ? 1 : 2; end
    endfunction

    function automatic void advance(input int l, input int t);
        case (m_st[l])
            0: m_st[l] = t;
            1, 2: if (t != m_st[l]) begin m_st[l] = 3; m_cnt[l] = DT - 1; end
            default: begin
                if (m_cnt[l] == 0) m_st[l] = t;
                else m_cnt[l] = m_cnt[l] - 1;
            end
        endcase
    endfunction

    task automatic step(input string tag, input logic rn, sb, d, e, ds, c, cs, z,
                        input int n);
        for (int i = 0; i < n; i++) begin
            int ta, tb;
            exp_t x;
            @(negedge clk);
            rst_n = rn; standby_n = sb; dir = d; en = e; decay_sel = ds;
            chop = c; chop_slow = cs; zero_cur = z;
            if (!rn) begin
                m_st[0] = 0; m_st[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
            end else begin
                targets(sb, d, e, ds, c, cs, z, ta, tb);
                advance(0, ta);
                advance(1, tb);
            end
            x.v   = {m_st[0] == 1, m_st[0] == 2, m_st[1] == 1, m_st[1] == 2};
            x.tag = tag;
            exp_q.push_back(x);
        end
    endtask

    // Monitor: compare one expected item per clock edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if ({hs_a, ls_a, hs_b, ls_b} !== e.v) begin
                fails++;
                $display("FAIL %s: {hs_a,ls_a,hs_b,ls_b} actual %b expected %b at %0t",
                         e.tag, {hs_a, ls_a, hs_b, ls_b}, e.v, $time);
            end
        end
    end

    initial begin
        //    tag    rn sb d  e  ds c  cs z  n
        step("R10", 0, 1, 1, 1, 0, 0, 0, 0, 3);
        step("R10", 1, 1, 1, 1, 0, 0, 0, 0, 1);
        step("R1",  1, 1, 1, 1, 0, 0, 0, 0, 6);
        step("R6",  1, 1, 1, 1, 0, 0, 0, 1, 5);
        step("R2",  1, 1, 0, 1, 0, 0, 0, 0, 12);
        step("R6",  1, 1, 0, 1, 0, 0, 0, 1, 4);
        step("R3",  1, 1, 1, 0, 1, 0, 0, 0, 10);
        step("R3",  1, 1, 0, 0, 1, 0, 0, 1, 8);
        step("R4",  1, 1, 1, 0, 0, 0, 0, 0, 12);
        step("R4",  1, 1, 0, 0, 0, 0, 0, 0, 12);
        step("R6",  1, 1, 0, 0, 0, 0, 0, 1, 10);
        step("R1",  1, 1, 1, 1, 0, 0, 0, 0, 10);
        step("R7",  1, 1, 1, 1, 0, 1, 0, 0, 8);
        step("R7",  1, 1, 1, 1, 0, 1, 1, 0, 10);
        step("R7",  1, 1, 1, 1, 0, 1, 0, 0, 10);
        step("R2",  1, 1, 0, 1, 0, 0, 0, 0, 12);
        step("R7",  1, 1, 0, 1, 0, 1, 1, 0, 10);
        step("R7",  1, 1, 0, 1, 0, 1, 0, 0, 10);
        step("R5",  1, 0, 1, 1, 0, 1, 1, 0, 8);
        step("R5",  1, 0, 0, 0, 1, 0, 0, 0, 4);
        step("R10", 1, 1, 1, 1, 0, 0, 0, 0, 6);
        step("R8",  1, 1, 0, 1, 0, 0, 0, 0, 2);
        step("R8",  1, 1, 1, 1, 0, 0, 0, 0, 12);
        step("R9",  1, 1, 0, 0, 0, 0, 0, 0, 3);
        step("R9",  1, 1, 0, 0, 1, 0, 0, 0, 12);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule